// File: doc/BRIEF.md
# Carrier Frequency Search Sweeper

This block drives the frequency word of a carrier numerically controlled oscillator through a stepped search while a receiver tries to acquire a signal. Software programs four values through a small synchronous write port: the frequency to begin at, the increment between trial frequencies, how many symbol periods to stay at each trial frequency, and how many trial frequencies make up one pass. The receiver's symbol-tick strobe paces the dwell. Lock is detected elsewhere and arrives as an input flag.

While enabled, the block stays at each trial frequency for the programmed number of symbol ticks. If no lock is seen, it moves to the next frequency. After the last trial frequency of a pass it returns to the start and searches again, for as long as it stays enabled. A lock seen during a dwell halts the stepping. Software then clears the enable, which freezes the frequency word at the locked value.

Top module: `freq_sweeper`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears after that edge: `freq_word` is 0, `sweep_active`, `lock_hold` and `pass_wrap` are 0, and `step_index` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into one register, chosen by `cfg_sel`: 0 is the start frequency (20 bits), 1 is the step (low 16 bits), 2 is the dwell in symbol ticks (low 16 bits), and 3 is the search count (low 8 bits). A write never changes `freq_word` by itself.
- R3: The first edge that samples `sweep_en` high while `sweep_active` is low loads the start frequency into `freq_word` and sets `sweep_active`. A `sym_tick` sampled at that same edge is not counted.
- R4: While sweeping without lock, `freq_word` changes at the edge that samples the dwell-th `sym_tick` since the frequency last changed. Between those edges it stays the same.
- R5: The next frequency is the current word plus the zero-extended 16-bit step, taken modulo 2^20.
- R6: `step_index` counts trial frequencies from 0 up to count-1. When a dwell ends at index count-1, `freq_word` returns to the start frequency and `step_index` returns to 0, and `pass_wrap` is high for exactly the one cycle that follows.
- R7: While sweeping, `lock_in` high at an edge holds `freq_word` and `step_index` and sets `lock_hold` after that edge. The dwell count starts again from zero, so a full dwell follows once lock drops.
- R8: With `sweep_en` low, `freq_word` holds its value whatever `sym_tick` and `lock_in` do, and `sweep_active` and `step_index` read 0.
- R9: Enabling again after an inhibit reloads the start frequency and starts a fresh dwell at index 0.
- R10: A dwell of 0 acts as one symbol tick. A search count of 0 acts as a single trial frequency, so every expired dwell returns the word to the start and pulses `pass_wrap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R2) |
| cfg_wdata | input | 20 | Register write data |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| lock_in | input | 1 | Carrier lock indication |
| sweep_en | input | 1 | High to sweep, low to inhibit |
| freq_word | output | 20 | Frequency command to the oscillator |
| sweep_active | output | 1 | Sweep running |
| lock_hold | output | 1 | Stepping halted by lock |
| pass_wrap | output | 1 | One-cycle pulse on return to start |
| step_index | output | 8 | Index of the current trial frequency |

## Verification
All outputs are registered, so every result is due in the cycle right after the edge that samples its cause. That edge may be the enabling edge, the edge of the dwell-th tick, a lock edge or an inhibit edge. The driver applies each stimulus at a falling edge and queues the expected outputs just after the next rising edge. The monitor compares them at the falling edge that follows, one clock after the stimulus. Dwell boundaries are tested by stepping one tick at a time and expecting no change on the ticks before the last one.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_STEP  = 2'd1,
    SEL_DWELL = 2'd2,
    SEL_COUNT = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fsw_cfg_regs.sv
module fsw_cfg_regs
  import fsw_pkg::*;
#(
  parameter int FREQ_W  = 20,
  parameter int STEP_W  = 16,
  parameter int DWELL_W = 16,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [FREQ_W-1:0]  wdata,
  output logic [FREQ_W-1:0]  start_o,
  output logic [STEP_W-1:0]  step_o,
  output logic [DWELL_W-1:0] dwell_o,
  output logic [CNT_W-1:0]   count_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= '0;
      step_o  <= '0;
      dwell_o <= '0;
      count_o <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_START: start_o <= wdata;
        SEL_STEP:  step_o  <= wdata[STEP_W-1:0];
        SEL_DWELL: dwell_o <= wdata[DWELL_W-1:0];
        SEL_COUNT: count_o <= wdata[CNT_W-1:0];
        default:   ;
      endcase
    end
  end

  // R2: a write to the start register lands on the next edge
  assert_start_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd0) |=> start_o == $past(wdata));
endmodule

// File: rtl/fsw_dwell_timer.sv
module fsw_dwell_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic [W-1:0] limit_eff;
  logic [W:0]   cnt_nxt;

  assign limit_eff = (limit == '0) ? W'(1) : limit;
  assign cnt_nxt   = {1'b0, cnt} + (W+1)'(1);
  assign expire    = tick && !restart && (cnt_nxt >= {1'b0, limit_eff});

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= expire ? '0 : cnt_nxt[W-1:0];
  end

  // R4: every expiry begins a new dwell from zero
  assert_dwell_restart_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == '0);
  // R7: a restart request (lock or idle) empties the count
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);
endmodule

// File: rtl/fsw_index_ctr.sv
module fsw_index_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] limit,
  output logic         last,
  output logic [W-1:0] idx
);
  logic [W-1:0] limit_eff;
  logic [W:0]   idx_nxt;

  assign limit_eff = (limit == '0) ? W'(1) : limit;
  assign idx_nxt   = {1'b0, idx} + (W+1)'(1);
  assign last      = idx_nxt >= {1'b0, limit_eff};

  always_ff @(posedge clk) begin
    if (rst || clear)  idx <= '0;
    else if (advance)  idx <= last ? '0 : idx_nxt[W-1:0];
  end

  // R6: finishing the last trial frequency returns the index to zero
  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (advance && last && !clear) |=> idx == '0);
endmodule

// File: rtl/freq_sweeper.sv
module freq_sweeper #(
  parameter int FREQ_W  = 20,
  parameter int STEP_W  = 16,
  parameter int DWELL_W = 16,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [FREQ_W-1:0] cfg_wdata,
  input  logic              sym_tick,
  input  logic              lock_in,
  input  logic              sweep_en,
  output logic [FREQ_W-1:0] freq_word,
  output logic              sweep_active,
  output logic              lock_hold,
  output logic              pass_wrap,
  output logic [CNT_W-1:0]  step_index
);
  logic [FREQ_W-1:0]  start_r;
  logic [STEP_W-1:0]  step_r;
  logic [DWELL_W-1:0] dwell_r;
  logic [CNT_W-1:0]   count_r;
  logic               run, start_pulse, restart, advance, last;

  fsw_cfg_regs #(.FREQ_W(FREQ_W), .STEP_W(STEP_W), .DWELL_W(DWELL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .start_o(start_r), .step_o(step_r), .dwell_o(dwell_r), .count_o(count_r)
  );

  assign run         = sweep_en && sweep_active;
  assign start_pulse = sweep_en && !sweep_active;
  assign restart     = !run || lock_in;

  fsw_dwell_timer #(.W(DWELL_W)) u_dwell (
    .clk(clk), .rst(rst), .restart(restart), .tick(sym_tick),
    .limit(dwell_r), .expire(advance)
  );

  fsw_index_ctr #(.W(CNT_W)) u_index (
    .clk(clk), .rst(rst), .clear(!run), .advance(advance),
    .limit(count_r), .last(last), .idx(step_index)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_word    <= '0;
      sweep_active <= 1'b0;
      lock_hold    <= 1'b0;
      pass_wrap    <= 1'b0;
    end else begin
      sweep_active <= sweep_en;
      lock_hold    <= run && lock_in;
      pass_wrap    <= advance && last;
      if (start_pulse)  freq_word <= start_r;
      else if (advance) freq_word <= last ? start_r : freq_word + FREQ_W'(step_r);
    end
  end

  // R8: inhibited sweep never moves the frequency word
  assert_hold_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
    (!sweep_en) |=> (rst || $stable(freq_word)));
  // R7: lock during a running sweep freezes the word
  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (run && lock_in) |=> (rst || $stable(freq_word)));
  // R3: enabling loads the programmed start value
  assert_enable_load_R3: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> (rst || freq_word == $past(start_r)));
  // R6: the wrap flag is a single-cycle pulse
  assert_wrap_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    pass_wrap |=> (rst || !pass_wrap || $past(advance)));
endmodule

// File: tb/freq_sweeper_bench.sv
`timescale 1ns/1ps
module freq_sweeper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [19:0] cfg_wdata = '0;
  logic        sym_tick = 1'b0, lock_in = 1'b0, sweep_en = 1'b0;
  logic [19:0] freq_word;
  logic        sweep_active, lock_hold, pass_wrap;
  logic [7:0]  step_index;

  always #4 clk = ~clk;

  freq_sweeper u_freq_sweeper (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .sym_tick(sym_tick), .lock_in(lock_in), .sweep_en(sweep_en),
    .freq_word(freq_word), .sweep_active(sweep_active), .lock_hold(lock_hold),
    .pass_wrap(pass_wrap), .step_index(step_index)
  );

  typedef struct packed {
    logic [19:0] f;
    logic        a;
    logic        w;
    logic        l;
    logic [7:0]  i;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  got;
      string t;
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      got = '{freq_word, sweep_active, pass_wrap, lock_hold, step_index};
      n_chk++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: got f=%h act=%b wrap=%b lh=%b idx=%0d, exp f=%h act=%b wrap=%b lh=%b idx=%0d",
                 t, got.f, got.a, got.w, got.l, got.i, e.f, e.a, e.w, e.l, e.i);
      end
    end
  end

  task automatic cyc(input logic en, input logic tk, input logic lk,
                     input logic [19:0] ef, input logic ea, input logic ew,
                     input logic el, input logic [7:0] ei, input string tag);
    @(negedge clk);
    sweep_en = en; sym_tick = tk; lock_in = lk;
    @(posedge clk);
    #1;
    sym_tick = 1'b0;
    exp_q.push_back('{ef, ea, ew, el, ei});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cyc(0, 0, 0, 20'h0, 0, 0, 0, 0, "R1 reset");
    rst = 1'b0;
    // R2 writes: 0 start, 1 step, 2 dwell, 3 count; freq untouched
    wr(2'd0, 20'h12340);
    wr(2'd1, 20'h00100);
    wr(2'd2, 20'd3);
    wr(2'd3, 20'd4);
    cyc(0, 0, 0, 20'h0, 0, 0, 0, 0, "R2 write no effect");
    // R3 enable loads start, tick on that edge ignored
    cyc(1, 1, 0, 20'h12340, 1, 0, 0, 0, "R3 enable load");
    // R4 dwell of 3 ticks
    cyc(1, 1, 0, 20'h12340, 1, 0, 0, 0, "R4 tick1");
    cyc(1, 0, 0, 20'h12340, 1, 0, 0, 0, "R4 idle");
    cyc(1, 1, 0, 20'h12340, 1, 0, 0, 0, "R4 tick2");
    cyc(1, 1, 0, 20'h12440, 1, 0, 0, 1, "R4 step at tick3");
    for (int k = 2; k <= 3; k++) begin
      cyc(1, 1, 0, 20'h12340 + 20'((k-1) * 'h100), 1, 0, 0, 8'(k-1), "R5 dwell");
      cyc(1, 1, 0, 20'h12340 + 20'((k-1) * 'h100), 1, 0, 0, 8'(k-1), "R5 dwell");
      cyc(1, 1, 0, 20'h12340 + 20'(k * 'h100), 1, 0, 0, 8'(k), "R5 step add");
    end
    // R6 wrap after 4 frequencies
    cyc(1, 1, 0, 20'h12640, 1, 0, 0, 3, "R6 pre");
    cyc(1, 1, 0, 20'h12640, 1, 0, 0, 3, "R6 pre");
    cyc(1, 1, 0, 20'h12340, 1, 1, 0, 0, "R6 wrap to start");
    cyc(1, 0, 0, 20'h12340, 1, 0, 0, 0, "R6 wrap one cycle");
    // R7 lock freeze, dwell restart
    cyc(1, 1, 0, 20'h12340, 1, 0, 0, 0, "R7 partial dwell");
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 20'h12340, 1, 0, 1, 0, "R7 locked hold");
    cyc(1, 1, 0, 20'h12340, 1, 0, 0, 0, "R7 unlock tick1");
    cyc(1, 1, 0, 20'h12340, 1, 0, 0, 0, "R7 unlock tick2");
    cyc(1, 1, 0, 20'h12440, 1, 0, 0, 1, "R7 full dwell after lock");
    // R8 inhibit holds
    for (int k = 0; k < 4; k++) cyc(0, 1, k[0], 20'h12440, 0, 0, 0, 0, "R8 inhibit hold");
    wr(2'd0, 20'hFFF80);
    cyc(0, 0, 0, 20'h12440, 0, 0, 0, 0, "R2 start write while idle");
    // R9 re-enable reloads, R5 modulo overflow
    cyc(1, 1, 0, 20'hFFF80, 1, 0, 0, 0, "R9 reload start");
    cyc(1, 1, 0, 20'hFFF80, 1, 0, 0, 0, "R9 fresh dwell");
    cyc(1, 1, 0, 20'hFFF80, 1, 0, 0, 0, "R9 fresh dwell");
    cyc(1, 1, 0, 20'h00080, 1, 0, 0, 1, "R5 overflow wraps mod 2^20");
    // R10 dwell 0 and count 0
    cyc(0, 0, 0, 20'h00080, 0, 0, 0, 0, "R8 inhibit");
    wr(2'd2, 20'd0);
    wr(2'd3, 20'd0);
    cyc(1, 0, 0, 20'hFFF80, 1, 0, 0, 0, "R9 reenable");
    cyc(1, 1, 0, 20'hFFF80, 1, 1, 0, 0, "R10 single freq wrap");
    cyc(1, 0, 0, 20'hFFF80, 1, 0, 0, 0, "R10 pulse ends");
    cyc(1, 1, 0, 20'hFFF80, 1, 1, 0, 0, "R10 dwell0 one tick");
    wr(2'd3, 20'd2);
    cyc(1, 1, 0, 20'h00080, 1, 0, 0, 1, "R10 dwell0 step");
    cyc(1, 1, 0, 20'hFFF80, 1, 1, 0, 0, "R6 count2 wrap");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule